// File: doc/BRIEF.md
# Floating-point result fixup stage

This block is a purely combinational correction stage placed after a floating-point arithmetic unit. It receives the raw rounded result, the first operand as actually presented to the adder or multiplier, and a result computed with round-toward-zero. It also receives a precision select and two mode bits taken from the floating-point status word: flush-to-zero and default-NaN. It returns the architecturally correct result word and an underflow indication.

Three corrections are applied. The first handles a NaN result: it is replaced either by the canonical quiet NaN or by the first operand made quiet. The second handles a subnormal result when flush-to-zero is on: it becomes a zero that keeps the result's sign. The third handles underflow, which is judged on tininess before rounding. When the rounded result is exactly the smallest normal magnitude, the truncated result decides whether underflow is signalled. For subtract-style fused operations, the caller presents the negated operand so that a propagated NaN carries the negated sign.

Internally a result-kind selector (NAN, FLUSH, MINCHK, PASS) is decoded each cycle with a fixed priority: NAN first, then FLUSH, then MINCHK, and PASS for everything else. There are no stored states and no transitions. The selector is a pure function of the current inputs.

Top module: `fp_result_fixup`

## Requirements
- R1: In single precision (dbl_sel=0), a NaN raw result (bits 30:23 all ones, bits 22:0 nonzero) gives 0x00000000_7FC00000 when dnan_en=1 or when op_a is not a single NaN.
- R2: In double precision (dbl_sel=1), a NaN raw result (bits 62:52 all ones, bits 51:0 nonzero) gives 0x7FF8000000000000 when dnan_en=1 or when op_a is not a double NaN.
- R3: With a NaN raw result, dnan_en=0 and op_a a NaN of the selected precision, the output is op_a OR'd with the quiet pattern of that precision (0x7FC00000 or 0x7FF8000000000000). Sign and payload are kept and the quiet bit (22 or 51) is forced to 1.
- R4: A subnormal raw result (exponent zero, fraction nonzero) with flush_en=1 becomes a zero carrying only the sign bit (bit 31 or bit 63), and uflow=1.
- R5: A subnormal raw result with flush_en=0 passes through unchanged, with uflow=0.
- R6: When the raw result is the smallest normal magnitude of either sign (exponent field 1, fraction 0), it passes through unchanged. uflow is 1 exactly when trunc_res is not normal, where not normal means exponent all zeros or all ones.
- R7: Any other raw result (zero, normal, infinity) passes through unchanged, with uflow=0.
- R8: In single precision, bits 63:32 of raw_res, op_a and trunc_res have no effect, and fixed_res bits 63:32 are 0.
- R9: A NaN raw result never raises uflow, and NaN handling takes priority over flushing and the smallest-normal check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dbl_sel | input | 1 | 1 selects double-precision fields, 0 selects single precision in bits 31:0 |
| flush_en | input | 1 | Flush-to-zero mode bit |
| dnan_en | input | 1 | Default-NaN mode bit |
| raw_res | input | 64 | Rounded result from the arithmetic unit |
| op_a | input | 64 | First operand as presented (already negated for subtract forms) |
| trunc_res | input | 64 | Same operation rounded toward zero |
| fixed_res | output | 64 | Corrected result |
| uflow | output | 1 | Underflow indication |

## Verification
The bench builds the block with the package defaults: an 8/23 single format inside a 64-bit word and an 11/52 double format. Both precisions are therefore exercised, including garbage in the upper half during single-precision operation. Because the operand generator picks a class first (zero, subnormal, smallest normal, normal, infinity, NaN), rare encodings such as the smallest normal with a subnormal truncated result or a signalling NaN operand show up often. Directed cases pin down the exact canonical NaN words, sign-only zeros and the NaN-over-flush priority.

// File: rtl/fixup_pkg.sv
`timescale 1ns/1ps
package fixup_pkg;
    localparam int WORD_W     = 64;
    localparam int HALF_W     = WORD_W / 2;
    localparam int SGL_EXP_W  = 8;
    localparam int SGL_FRAC_W = HALF_W - 1 - SGL_EXP_W;
    localparam int DBL_EXP_W  = 11;
    localparam int DBL_FRAC_W = WORD_W - 1 - DBL_EXP_W;

    localparam logic [WORD_W-1:0] SGL_QNAN =
        {{HALF_W{1'b0}}, 1'b0, {SGL_EXP_W{1'b1}}, 1'b1, {(SGL_FRAC_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] DBL_QNAN =
        {1'b0, {DBL_EXP_W{1'b1}}, 1'b1, {(DBL_FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic sign;
        logic is_nan;
        logic is_sub;
        logic is_norm;
        logic is_min;
    } fp_cls_t;

    typedef enum logic [1:0] {
        K_PASS   = 2'd0,
        K_NAN    = 2'd1,
        K_FLUSH  = 2'd2,
        K_MINCHK = 2'd3
    } fix_kind_e;
endpackage

// File: rtl/fp_class.sv
`timescale 1ns/1ps
module fp_class
    import fixup_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              dbl,
    output fp_cls_t           cls
);
    logic e_zero, e_ones, e_one, f_nz, s;

    always_comb begin
        if (dbl) begin
            s      = word[WORD_W-1];
            e_zero = (word[WORD_W-2 -: DBL_EXP_W] == '0);
            e_ones = (word[WORD_W-2 -: DBL_EXP_W] == '1);
            e_one  = (word[WORD_W-2 -: DBL_EXP_W] == DBL_EXP_W'(1));
            f_nz   = (word[DBL_FRAC_W-1:0] != '0);
        end else begin
            s      = word[HALF_W-1];
            e_zero = (word[HALF_W-2 -: SGL_EXP_W] == '0);
            e_ones = (word[HALF_W-2 -: SGL_EXP_W] == '1);
            e_one  = (word[HALF_W-2 -: SGL_EXP_W] == SGL_EXP_W'(1));
            f_nz   = (word[SGL_FRAC_W-1:0] != '0);
        end
    end

    assign cls.sign    = s;
    assign cls.is_nan  = e_ones & f_nz;
    assign cls.is_sub  = e_zero & f_nz;
    assign cls.is_norm = ~e_zero & ~e_ones;
    assign cls.is_min  = e_one & ~f_nz;
endmodule

// File: rtl/fp_nan_pick.sv
`timescale 1ns/1ps
module fp_nan_pick
    import fixup_pkg::*;
(
    input  logic              dbl,
    input  logic              dn_en,
    input  logic              op_nan,
    input  logic [WORD_W-1:0] op,
    output logic [WORD_W-1:0] nan_word
);
    logic [WORD_W-1:0] quiet_pat;
    logic [WORD_W-1:0] op_fit;

    always_comb begin
        quiet_pat = dbl ? DBL_QNAN : SGL_QNAN;
        op_fit    = dbl ? op : {{HALF_W{1'b0}}, op[HALF_W-1:0]};
        if (dn_en || !op_nan)
            nan_word = quiet_pat;
        else
            nan_word = op_fit | quiet_pat;
    end
endmodule

// File: rtl/fp_result_fixup.sv
`timescale 1ns/1ps
module fp_result_fixup
    import fixup_pkg::*;
(
    input  logic              dbl_sel,
    input  logic              flush_en,
    input  logic              dnan_en,
    input  logic [WORD_W-1:0] raw_res,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] trunc_res,
    output logic [WORD_W-1:0] fixed_res,
    output logic              uflow
);
    fp_cls_t           raw_c, opa_c, trc_c, out_c;
    fix_kind_e         kind;
    logic [WORD_W-1:0] nan_word;
    logic [WORD_W-1:0] raw_fit;
    logic [WORD_W-1:0] sign_zero;

    fp_class u_raw_cls (.word(raw_res),   .dbl(dbl_sel), .cls(raw_c));
    fp_class u_opa_cls (.word(op_a),      .dbl(dbl_sel), .cls(opa_c));
    fp_class u_trc_cls (.word(trunc_res), .dbl(dbl_sel), .cls(trc_c));
    fp_class u_out_cls (.word(fixed_res), .dbl(dbl_sel), .cls(out_c));

    fp_nan_pick u_nan (
        .dbl      (dbl_sel),
        .dn_en    (dnan_en),
        .op_nan   (opa_c.is_nan),
        .op       (op_a),
        .nan_word (nan_word)
    );

    // result-kind selector, fixed priority
    always_comb begin
        if (raw_c.is_nan)
            kind = K_NAN;
        else if (raw_c.is_sub && flush_en)
            kind = K_FLUSH;
        else if (raw_c.is_min)
            kind = K_MINCHK;
        else
            kind = K_PASS;
    end

    always_comb begin
        raw_fit   = dbl_sel ? raw_res : {{HALF_W{1'b0}}, raw_res[HALF_W-1:0]};
        sign_zero = dbl_sel ? {raw_res[WORD_W-1], {(WORD_W-1){1'b0}}}
                            : {{HALF_W{1'b0}}, raw_res[HALF_W-1], {(HALF_W-1){1'b0}}};
    end

    always_comb begin
        unique case (kind)
            K_NAN: begin
                fixed_res = nan_word;
                uflow     = 1'b0;
            end
            K_FLUSH: begin
                fixed_res = sign_zero;
                uflow     = 1'b1;
            end
            K_MINCHK: begin
                fixed_res = raw_fit;
                uflow     = ~trc_c.is_norm;
            end
            default: begin
                fixed_res = raw_fit;
                uflow     = 1'b0;
            end
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{opa_c.is_sub, opa_c.is_norm, opa_c.is_min, opa_c.sign,
                           trc_c.sign, trc_c.is_nan, trc_c.is_sub, trc_c.is_min,
                           raw_c.is_norm, out_c.is_min};

    always_comb begin
        // R4
        flush_zero_chk: assert (!(raw_c.is_sub && flush_en) ||
            (uflow && !out_c.is_sub && !out_c.is_norm && !out_c.is_nan && out_c.sign == raw_c.sign))
            else $error("flush result not a signed zero");
        // R9
        nan_out_chk: assert (!raw_c.is_nan || (out_c.is_nan && !uflow))
            else $error("NaN result lost or flagged");
        // R8
        upper_clear_chk: assert (dbl_sel || fixed_res[WORD_W-1:HALF_W] == '0)
            else $error("upper half set in single mode");
        // R6
        uflow_cause_chk: assert (!uflow || raw_c.is_min || (raw_c.is_sub && flush_en))
            else $error("underflow without cause");
        // R3
        prop_sign_chk: assert (!(raw_c.is_nan && !dnan_en && opa_c.is_nan) || out_c.sign == opa_c.sign)
            else $error("propagated NaN sign wrong");
    end
endmodule

// File: tb/fp_result_fixup_test.sv
`timescale 1ns/1ps
module fp_result_fixup_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbl_sel, flush_en, dnan_en;
    logic [63:0] raw_res, op_a, trunc_res;
    logic [63:0] fixed_res;
    logic        uflow;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    fp_result_fixup uut (
        .dbl_sel(dbl_sel), .flush_en(flush_en), .dnan_en(dnan_en),
        .raw_res(raw_res), .op_a(op_a), .trunc_res(trunc_res),
        .fixed_res(fixed_res), .uflow(uflow)
    );

    function automatic int ex(bit d, logic [63:0] x);
        return d ? int'(x[62:52]) : int'(x[30:23]);
    endfunction
    function automatic bit fnz(bit d, logic [63:0] x);
        return d ? (x[51:0] != 0) : (x[22:0] != 0);
    endfunction
    function automatic int emax(bit d);
        return d ? 2047 : 255;
    endfunction
    function automatic bit is_nan(bit d, logic [63:0] x);
        return ex(d, x) == emax(d) && fnz(d, x);
    endfunction
    function automatic bit is_sub(bit d, logic [63:0] x);
        return ex(d, x) == 0 && fnz(d, x);
    endfunction
    function automatic bit is_min(bit d, logic [63:0] x);
        return ex(d, x) == 1 && !fnz(d, x);
    endfunction
    function automatic bit is_norm(bit d, logic [63:0] x);
        return ex(d, x) != 0 && ex(d, x) != emax(d);
    endfunction

    task automatic model(input bit d, ftz, dn, input logic [63:0] r, a, t,
                         output logic [63:0] er, output bit eu, output string tag);
        logic [63:0] qn, rm, am;
        qn = d ? 64'h7FF8000000000000 : 64'h0000_0000_7FC0_0000;
        rm = d ? r : {32'h0, r[31:0]};
        am = d ? a : {32'h0, a[31:0]};
        if (is_nan(d, r)) begin
            eu = 0;
            if (dn || !is_nan(d, a)) begin er = qn; tag = d ? "R2" : "R1"; end
            else begin er = am | qn; tag = "R3"; end
        end else if (is_sub(d, r) && ftz) begin
            er = d ? {r[63], 63'h0} : {32'h0, r[31], 31'h0}; eu = 1; tag = "R4";
        end else if (is_sub(d, r)) begin
            er = rm; eu = 0; tag = "R5";
        end else if (is_min(d, r)) begin
            er = rm; eu = !is_norm(d, t); tag = "R6";
        end else begin
            er = rm; eu = 0; tag = "R7";
        end
    endtask

    function automatic logic [63:0] mk(bit d, int cls);
        logic [63:0] v;
        logic [51:0] f;
        int          e;
        bit          s;
        s = 1'($urandom);
        f = {20'($urandom), $urandom};
        case (cls)
            0: begin e = 0; f = 0; end
            1: begin e = 0; f = f | 52'd1; end
            2: begin e = 1; f = 0; end
            3: begin e = 1 + int'($urandom % 32'(emax(d) - 1)); end
            4: begin e = emax(d); f = 0; end
            default: begin e = emax(d); f = f | 52'd1; end
        endcase
        if (d) v = {s, 11'(e), f};
        else   v = {$urandom, s, 8'(e), f[22:0] | ((cls == 1 || cls >= 5) && f[22:0] == 0 ? 23'd1 : 23'd0)};
        return v;
    endfunction

    task automatic apply_chk(input bit d, ftz, dn, input logic [63:0] r, a, t,
                             input logic [63:0] er, input bit eu, input string tag);
        @(posedge clk);
        dbl_sel = d; flush_en = ftz; dnan_en = dn; raw_res = r; op_a = a; trunc_res = t;
        @(negedge clk);
        n_chk++;
        if (fixed_res !== er || uflow !== eu) begin
            n_bad++;
            $display("FAIL %s: got res=%h uf=%b, expected res=%h uf=%b", tag, fixed_res, uflow, er, eu);
        end
    endtask

    task automatic run_rand(input bit d, ftz, dn, input logic [63:0] r, a, t);
        logic [63:0] er; bit eu; string tag;
        model(d, ftz, dn, r, a, t, er, eu, tag);
        apply_chk(d, ftz, dn, r, a, t, er, eu, tag);
    endtask

    initial begin
        dbl_sel = 0; flush_en = 0; dnan_en = 0; raw_res = 0; op_a = 0; trunc_res = 0;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R7 idle state: all-zero inputs
        apply_chk(0, 0, 0, 64'h0, 64'h0, 64'h0, 64'h0, 0, "R7");
        // R1
        apply_chk(0, 0, 1, 64'h7F800001, 64'hFF800003, 0, 64'h7FC00000, 0, "R1");
        apply_chk(0, 0, 0, 64'hFFC00000, 64'h3F800000, 0, 64'h7FC00000, 0, "R1");
        // R2
        apply_chk(1, 0, 0, 64'hFFF0000000000001, 64'h4000000000000000, 0, 64'h7FF8000000000000, 0, "R2");
        apply_chk(1, 1, 1, 64'h7FF8000000000000, 64'h7FF0000000000009, 0, 64'h7FF8000000000000, 0, "R2");
        // R3
        apply_chk(0, 0, 0, 64'h7FC00000, 64'hFF800001, 0, 64'hFFC00001, 0, "R3");
        apply_chk(1, 0, 0, 64'h7FF8000000000000, 64'hFFF0000000000005, 0, 64'hFFF8000000000005, 0, "R3");
        // R4
        apply_chk(0, 1, 0, 64'h80000005, 0, 0, 64'h80000000, 1, "R4");
        apply_chk(1, 1, 0, 64'h000FFFFFFFFFFFFF, 0, 0, 64'h0, 1, "R4");
        // R5
        apply_chk(0, 0, 0, 64'h00000005, 0, 0, 64'h00000005, 0, "R5");
        // R6
        apply_chk(0, 0, 0, 64'h00800000, 0, 64'h007FFFFF, 64'h00800000, 1, "R6");
        apply_chk(0, 0, 0, 64'h80800000, 0, 64'h80800000, 64'h80800000, 0, "R6");
        apply_chk(1, 0, 0, 64'h8010000000000000, 0, 64'h0, 64'h8010000000000000, 1, "R6");
        // R7
        apply_chk(1, 1, 0, 64'hFFF0000000000000, 0, 0, 64'hFFF0000000000000, 0, "R7");
        // R8
        apply_chk(0, 0, 0, 64'hDEADBEEF3F800000, 0, 0, 64'h3F800000, 0, "R8");
        apply_chk(0, 0, 0, 64'hFFFFFFFF00000000, 0, 0, 64'h0, 0, "R8");
        apply_chk(0, 0, 0, 64'h7FC0000100800000, 0, 64'h1234567800800000, 64'h00800000, 0, "R8");
        // R9: NaN wins over flush, no underflow
        apply_chk(0, 1, 1, 64'hFF800001, 0, 64'h00000001, 64'h7FC00000, 0, "R9");
        for (int i = 0; i < 3000; i++) begin
            bit d;
            d = 1'($urandom);
            run_rand(d, 1'($urandom), 1'($urandom),
                     mk(d, int'($urandom % 6)), mk(d, int'($urandom % 6)), mk(d, int'($urandom % 6)));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule